// File: doc/BRIEF.md
# CAM Bus Cycle Sequencer

This block sits on the host side of a 16-bit data bus to a chain of external content-addressable memories. It takes one request at a time through a simple valid-qualified interface. The request carries a two-bit cycle kind, a write value and a match-qualify option. The block then runs one bus cycle, with fixed timing, on the chip-enable, write-gate, command-select and chain-enable strobes. All of these strobes are low-active.

Write-kind cycles drive the data bus. Read-kind cycles release it and capture the value returned by the memory. When a read result has been posted, the block pulls a low-active interrupt. A status read from the host releases it.

The match flag and the full flag from the end of the chain are also low-active. Each passes through a two-flop synchronizer and is then reported as a high-active status bit.

Top module: `cambus_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. After that edge: `ce_n`, `wg_n`, `cs_n`, `dce_n` and `irq_n` are 1; `bus_oe`, `busy` and `done` are 0; `rd_data` is 0. Reset is synchronous.
- R2: A request accepted at edge E0 runs as follows.
  - After E0: setup, with `ce_n` high.
  - After E0+1: `ce_n` low for exactly one clock.
  - After E0+2: recovery, with `ce_n` high.
  - After E0+3: the block is idle again and `done` is high for exactly one clock.
- R3: The kind encoding is `req_kind[1]` → `cs_n` and `req_kind[0]` → `wg_n`.
  - 0: command or configuration write.
  - 1: configuration-register read.
  - 2: data or memory write.
  - 3: data or memory read.
  - These levels hold from setup through recovery, so they are stable when `ce_n` falls.
- R4: For write kinds (`req_kind[0]`=0), `bus_oe` is high and `bus_out` equals the request value from setup through recovery. For read kinds and in idle, `bus_oe` is low, so it is already off in the clock before `ce_n` falls.
- R5: On a read kind, `rd_data` takes the value on `bus_in` at the edge where `ce_n` returns high. Later changes of `bus_in` and write cycles leave `rd_data` unchanged.
- R6: During a cycle, `dce_n` equals the inverse of `req_qual`, so a qualified access drives it low. In idle, `dce_n` is high.
- R7: `busy` is high from setup through recovery. A `req_valid`, kind, value or qualify change while busy has no effect on the running cycle and starts no new cycle.
- R8: `irq_n` goes low together with `done` at the end of a read-kind cycle. A `stat_rd` pulse returns it high on the next clock. Write-kind cycles do not lower it. If a read result is posted on the same edge as `stat_rd`, the posting wins.
- R9: `match_hit` equals the inverse of `match_n`, and `chain_full` equals the inverse of `full_n`. Each follows its input two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_kind | input | 2 | Cycle kind: bit 1 gives command-select, bit 0 gives write-gate |
| req_wdata | input | 16 | Value driven on write kinds |
| req_qual | input | 1 | Restrict the access to the matching device |
| stat_rd | input | 1 | Host read of the result; clears the interrupt |
| bus_in | input | 16 | Data bus as seen from the pins |
| bus_out | output | 16 | Data bus drive value |
| bus_oe | output | 1 | Data bus output enable |
| ce_n | output | 1 | Chip enable, active low |
| wg_n | output | 1 | Write gate, active low |
| cs_n | output | 1 | Command select, active low |
| dce_n | output | 1 | Chain enable, active low |
| match_n | input | 1 | Match flag from the chain, active low |
| full_n | input | 1 | Full flag from the chain, active low |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock pulse when a cycle ends |
| rd_data | output | 16 | Last captured read value |
| irq_n | output | 1 | Result interrupt, active low |
| match_hit | output | 1 | Synchronized match status |
| chain_full | output | 1 | Synchronized full status |

## Verification
All four kinds are run with random values and a random qualify bit, each with the strobe levels, drive enable and capture checked on every clock of the cycle. This separates a wrong kind decode from a wrong phase length.

The read value on the bus is flipped right after capture. This shows whether the capture happens at the enable rising edge or later. Requests held high with altered fields during a cycle show whether acceptance leaks outside idle.

Status reads are placed in idle gaps and on the very edge a read result is posted, which separates clear-over-set from set-over-clear. Flag steps are sampled one and two clocks later to pin the synchronizer depth.

// File: rtl/cambus_pkg.sv
package cambus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_STROBE  = 2'd2,
        ST_RECOVER = 2'd3
    } seq_st_e;

    // kind bit 1 -> command-select level, bit 0 -> write-gate level
    localparam int KIND_W     = 2;
    localparam int KIND_CS_B  = 1;
    localparam int KIND_WG_B  = 0;
endpackage

// File: rtl/cambus_sync.sv
module cambus_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= din;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/cambus_core.sv
module cambus_core
    import cambus_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [DW-1:0]     req_wdata,
    input  logic              req_qual,
    input  logic              stat_rd,
    input  logic [DW-1:0]     bus_in,
    output logic [DW-1:0]     bus_out,
    output logic              bus_oe,
    output logic              ce_n,
    output logic              wg_n,
    output logic              cs_n,
    output logic              dce_n,
    output logic              busy,
    output logic              done,
    output logic [DW-1:0]     rd_data,
    output logic              irq_n
);
    typedef struct packed {
        seq_st_e       st;
        logic          ce_n;
        logic          wg_n;
        logic          cs_n;
        logic          dce_n;
        logic          oe;
        logic [DW-1:0] wdat;
        logic [DW-1:0] rdat;
        logic          done;
        logic          irq_n;
    } regs_t;

    localparam regs_t RST_VAL = '{
        st: ST_IDLE, ce_n: 1'b1, wg_n: 1'b1, cs_n: 1'b1, dce_n: 1'b1,
        oe: 1'b0, wdat: '0, rdat: '0, done: 1'b0, irq_n: 1'b1
    };

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (stat_rd) begin
            r_d.irq_n = 1'b1;
        end
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_SETUP;
                    r_d.wg_n  = req_kind[KIND_WG_B];
                    r_d.cs_n  = req_kind[KIND_CS_B];
                    r_d.dce_n = ~req_qual;
                    r_d.oe    = ~req_kind[KIND_WG_B];
                    r_d.wdat  = req_wdata;
                end
            end
            ST_SETUP: begin
                r_d.st   = ST_STROBE;
                r_d.ce_n = 1'b0;
            end
            ST_STROBE: begin
                r_d.st   = ST_RECOVER;
                r_d.ce_n = 1'b1;
                if (r_q.wg_n) begin
                    r_d.rdat = bus_in;
                end
            end
            ST_RECOVER: begin
                r_d.st    = ST_IDLE;
                r_d.wg_n  = 1'b1;
                r_d.cs_n  = 1'b1;
                r_d.dce_n = 1'b1;
                r_d.oe    = 1'b0;
                r_d.done  = 1'b1;
                if (r_q.wg_n) begin
                    r_d.irq_n = 1'b0;
                end
            end
            default: r_d = RST_VAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_out = r_q.wdat;
    assign bus_oe  = r_q.oe;
    assign ce_n    = r_q.ce_n;
    assign wg_n    = r_q.wg_n;
    assign cs_n    = r_q.cs_n;
    assign dce_n   = r_q.dce_n;
    assign busy    = (r_q.st != ST_IDLE);
    assign done    = r_q.done;
    assign rd_data = r_q.rdat;
    assign irq_n   = r_q.irq_n;
endmodule

// File: rtl/cambus_seq.sv
module cambus_seq
    import cambus_pkg::*;
#(
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [DW-1:0]     req_wdata,
    input  logic              req_qual,
    input  logic              stat_rd,
    input  logic [DW-1:0]     bus_in,
    output logic [DW-1:0]     bus_out,
    output logic              bus_oe,
    output logic              ce_n,
    output logic              wg_n,
    output logic              cs_n,
    output logic              dce_n,
    input  logic              match_n,
    input  logic              full_n,
    output logic              busy,
    output logic              done,
    output logic [DW-1:0]     rd_data,
    output logic              irq_n,
    output logic              match_hit,
    output logic              chain_full
);
    localparam int FLAG_W = 2;
    logic [FLAG_W-1:0] flags_sync;

    cambus_core #(.DW(DW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_wdata (req_wdata),
        .req_qual  (req_qual),
        .stat_rd   (stat_rd),
        .bus_in    (bus_in),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .ce_n      (ce_n),
        .wg_n      (wg_n),
        .cs_n      (cs_n),
        .dce_n     (dce_n),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .irq_n     (irq_n)
    );

    cambus_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({~full_n, ~match_n}),
        .dout  (flags_sync)
    );

    assign match_hit  = flags_sync[0];
    assign chain_full = flags_sync[1];
endmodule

// File: rtl/cambus_seq_chk.sv
module cambus_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic wg_n,
    input logic cs_n,
    input logic dce_n,
    input logic bus_oe,
    input logic busy,
    input logic done,
    input logic irq_n,
    input logic stat_rd
);
    AST_STROBE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) !ce_n |=> ce_n); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
    AST_STROBES_SETTLED: assert property (@(posedge clk) disable iff (!rst_n) $fell(ce_n) |-> ($stable(wg_n) && $stable(cs_n) && $stable(dce_n))); // R3
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) (!ce_n && wg_n) |-> (!bus_oe && !$past(bus_oe))); // R4
    AST_IDLE_CHAIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (ce_n && dce_n && !bus_oe)); // R6
    AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(irq_n) |-> done); // R8
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (stat_rd && !done && !busy) |=> irq_n); // R8
endmodule

bind cambus_seq cambus_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .wg_n    (wg_n),
    .cs_n    (cs_n),
    .dce_n   (dce_n),
    .bus_oe  (bus_oe),
    .busy    (busy),
    .done    (done),
    .irq_n   (irq_n),
    .stat_rd (stat_rd)
);

// File: tb/cambus_seq_test.sv
module cambus_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_qual = 1'b0;
    logic          stat_rd = 1'b0;
    logic [DW-1:0] bus_in = '0;
    logic          match_n = 1'b1;
    logic          full_n = 1'b1;
    logic [DW-1:0] bus_out, rd_data;
    logic          bus_oe, ce_n, wg_n, cs_n, dce_n, busy, done, irq_n;
    logic          match_hit, chain_full;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [DW-1:0] exp_rd = '0;
    logic          exp_irq = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    cambus_seq #(.DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_wdata(req_wdata), .req_qual(req_qual), .stat_rd(stat_rd),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .ce_n(ce_n),
        .wg_n(wg_n), .cs_n(cs_n), .dce_n(dce_n), .match_n(match_n),
        .full_n(full_n), .busy(busy), .done(done), .rd_data(rd_data),
        .irq_n(irq_n), .match_hit(match_hit), .chain_full(chain_full)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            bad = bad + 1;
            $display("FAIL watchdog: act=%0d exp<=50000", cyc);
            $display("test done: total=%0d bad=%0d", total + 1, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] strobes_exp(input logic [1:0] k, input logic q);
        // {ce_n, cs_n, wg_n, dce_n} during setup/recovery
        return {1'b1, k[1], k[0], ~q};
    endfunction

    task automatic run_cycle(input logic [1:0] k, input logic [DW-1:0] wd, input logic q,
                             input logic [DW-1:0] rv, input bit hold, input bit clr_late);
        logic [3:0] s;
        bit rd;
        s  = strobes_exp(k, q);
        rd = k[0];
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_wdata = wd; req_qual = q; bus_in = rv;
        @(negedge clk); // setup
        chk({ce_n, cs_n, wg_n, dce_n} == s, "R3 setup strobes", {ce_n, cs_n, wg_n, dce_n}, s);
        chk(busy == 1'b1, "R7 busy in setup", busy, 1);
        chk(bus_oe == ~rd, "R4 oe in setup", bus_oe, ~rd);
        if (hold) begin
            req_kind = ~k; req_wdata = ~wd; req_qual = ~q;
        end else begin
            req_valid = 1'b0;
        end
        @(negedge clk); // strobe
        chk(ce_n == 1'b0, "R2 ce low in strobe", ce_n, 0);
        chk({cs_n, wg_n, dce_n} == s[2:0], "R6 strobe levels", {cs_n, wg_n, dce_n}, s[2:0]);
        chk(bus_oe == ~rd, "R4 oe in strobe", bus_oe, ~rd);
        if (!rd) chk(bus_out == wd, "R4 bus_out value", bus_out, wd);
        @(negedge clk); // recovery
        bus_in = ~rv;
        if (rd) exp_rd = rv;
        chk(ce_n == 1'b1 && busy == 1'b1, "R2 recovery", {ce_n, busy}, 2'b11);
        chk({cs_n, wg_n, dce_n} == s[2:0], "R7 levels held", {cs_n, wg_n, dce_n}, s[2:0]);
        chk(rd_data == exp_rd, "R5 capture", rd_data, exp_rd);
        if (clr_late) stat_rd = 1'b1;
        @(negedge clk); // idle, done
        req_valid = 1'b0; stat_rd = 1'b0;
        if (rd) exp_irq = 1'b0;
        else if (clr_late) exp_irq = 1'b1;
        chk(done == 1'b1 && busy == 1'b0, "R2 done pulse", {done, busy}, 2'b10);
        chk({ce_n, cs_n, wg_n, dce_n, bus_oe} == 5'b11110, "R6 idle strobes",
            {ce_n, cs_n, wg_n, dce_n, bus_oe}, 5'b11110);
        chk(irq_n == exp_irq, "R8 irq after cycle", irq_n, exp_irq);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R7 no restart", {done, busy}, 2'b00);
        chk(rd_data == exp_rd, "R5 hold", rd_data, exp_rd);
    endtask

    task automatic status_read();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        exp_irq = 1'b1;
        chk(irq_n == 1'b1, "R8 clear on status read", irq_n, 1);
    endtask

    task automatic flag_step(input logic m, input logic f);
        logic pm, pf;
        pm = ~match_n; pf = ~full_n;
        @(negedge clk);
        match_n = m; full_n = f;
        @(negedge clk);
        chk({match_hit, chain_full} == {pm, pf}, "R9 one clock old", {match_hit, chain_full}, {pm, pf});
        @(negedge clk);
        chk({match_hit, chain_full} == {~m, ~f}, "R9 two clocks", {match_hit, chain_full}, {~m, ~f});
    endtask

    initial begin
        void'($urandom(32'h5eed1));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk({ce_n, wg_n, cs_n, dce_n, irq_n} == 5'b11111, "R1 strobes", {ce_n, wg_n, cs_n, dce_n, irq_n}, 5'b11111);
        chk({bus_oe, busy, done} == 3'b000 && rd_data == '0, "R1 flags", {bus_oe, busy, done, rd_data}, 0);
        // directed: every kind
        run_cycle(2'd0, 16'hA5C3, 1'b0, 16'h1111, 0, 0);
        run_cycle(2'd2, 16'h0F0F, 1'b1, 16'h2222, 0, 0);
        run_cycle(2'd1, 16'h3333, 1'b0, 16'hBEEF, 0, 0);
        status_read();
        run_cycle(2'd3, 16'h4444, 1'b1, 16'hCAFE, 1, 0);
        status_read();
        // write must not set irq, late status read still clears
        run_cycle(2'd2, 16'hFFFF, 1'b1, 16'h0000, 1, 1);
        // read posting beats simultaneous status read
        run_cycle(2'd1, 16'h0001, 1'b0, 16'h8001, 0, 1);
        status_read();
        // status synchronizer
        flag_step(1'b0, 1'b1);
        flag_step(1'b1, 1'b0);
        flag_step(1'b0, 1'b0);
        flag_step(1'b1, 1'b1);
        // random mix
        for (int i = 0; i < 80; i++) begin
            run_cycle(2'($urandom), 16'($urandom), 1'($urandom), 16'($urandom),
                      1'($urandom), 1'($urandom % 4 == 0));
            if ($urandom % 3 == 0) status_read();
        end
        // reset mid-cycle returns to idle
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd3;
        @(negedge clk);
        req_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk({busy, ce_n, irq_n, bus_oe} == 4'b0110 && rd_data == '0, "R1 reset mid-cycle",
            {busy, ce_n, irq_n, bus_oe}, 4'b0110);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule